// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst in a synchronous memory interface. It has two address strobes. The controller strobe always loads the external address. The processor strobe loads it only while the primary chip enable is high. On a load the block also captures the chip enable, so the downstream array knows whether the new access selects it. After a load, the advance input steps the two low address bits through a four-entry sequence, giving the 3-1-1-1 access pattern: one initial access, then three burst beats. The upper bits stay fixed throughout.

A static order input picks the sequence. Linear order counts the low bits up modulo four from the loaded value. Interleaved order XORs the loaded low bits with a beat number that runs 0, 1, 2, 3. When neither a load nor an advance happens, the address holds, which suspends the burst. The address and select outputs are registered, so each change shows one clock after the edge that causes it.

Top module: `burst_addr_gen`

## Requirements
- R1: When `ctl_stb` is high at a rising edge, `addr_out` equals the `addr_in` of that edge and `sel_out` equals the `chip_en` of that edge, after the edge. This holds whatever the value of `chip_en`.
- R2: `cpu_stb` loads the address only when `chip_en` is high. With `chip_en` low, `cpu_stb` is ignored, and the address holds or advances as `advance` alone dictates.
- R3: When both strobes are high at the same edge, exactly one load occurs and the controller-strobe rule applies: the load happens even when `chip_en` is low, and `sel_out` then reads 0.
- R4: With `order_sel` = 0 (linear), each advance sets the two low bits to the loaded low bits plus the beat number, modulo 4. For example, a loaded value of 1 gives 1, 2, 3, 0.
- R5: With `order_sel` = 1 (interleaved), each advance sets the two low bits to the loaded low bits XOR the beat number, where the beat number is 1, 2, 3 and then 0.
- R6: Bits `addr_out[ADDR_W-1:2]` change only on a load. A wrap of the low bits never carries into them.
- R7: When no load occurs and `advance` is low, `addr_out` and `sel_out` hold their values (burst suspend).
- R8: A load takes precedence over `advance` at the same edge. The beat number restarts at 0.
- R9: While `rst` is high at a rising edge, `addr_out` and `sel_out` clear to 0 after that edge.
- R10: After four advances the beat number wraps, and the address returns to the loaded value. Further advances repeat the same sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_stb | input | 1 | Controller address strobe, active high, loads unconditionally |
| cpu_stb | input | 1 | Processor address strobe, active high, gated by `chip_en` |
| chip_en | input | 1 | Primary chip enable, captured on every load |
| advance | input | 1 | Steps the burst when no load occurs |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current registered word address |
| sel_out | output | 1 | Chip enable captured at the last load |

## Verification
Several properties are checked on every cycle:
- the load value and the captured select after a controller strobe;
- the hold when no load and no advance occur;
- the stability of the upper bits outside a load;
- the modulo-4 step of the low bits in linear order;
- the beat counter's increment and restart.

The exact interleaved sequence, the return to the start after the fourth beat, the rule that a gated processor strobe still lets an advance through, and the priority between the two strobes depend on the loaded base. Only the bench's scenarios show them, through the expected addresses each beat must produce.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt_q,
  output logic [BEAT_W-1:0] cnt_d
);
  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + BEAT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R8
  beat_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt_q == '0);

  // R10
  beat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> cnt_q == BEAT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/burst_lo_order.sv
module burst_lo_order
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] lo
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = base + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_lo[b] = base[b] ^ beat[b];
  end

  assign lo = (order == ORDER_XOR) ? xor_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_stb,
  input  logic              cpu_stb,
  input  logic              chip_en,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              sel_out
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic [BEAT_W-1:0] base_q;
  logic [BEAT_W-1:0] base_d;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_d;
  logic [BEAT_W-1:0] lo_d;
  logic [UP_W-1:0]   up_d;
  order_e            order;

  assign order = order_e'(order_sel);
  // controller strobe wins; processor strobe needs the chip enable
  assign load   = ctl_stb | (cpu_stb & chip_en);
  assign step   = advance & ~load;
  assign base_d = load ? addr_in[BEAT_W-1:0] : base_q;
  assign up_d   = load ? addr_in[ADDR_W-1:BEAT_W] : addr_out[ADDR_W-1:BEAT_W];

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst   (rst),
    .clear (load),
    .step  (step),
    .cnt_q (beat_q),
    .cnt_d (beat_d)
  );

  burst_lo_order #(.BEAT_W(BEAT_W)) u_order (
    .base  (base_d),
    .beat  (beat_d),
    .order (order),
    .lo    (lo_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      addr_out <= '0;
      sel_out  <= 1'b0;
    end else begin
      base_q   <= base_d;
      addr_out <= {up_d, lo_d};
      if (load) sel_out <= chip_en;
    end
  end

  // R1
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_stb |=> (addr_out == $past(addr_in)) && (sel_out == $past(chip_en)));

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_stb && !(cpu_stb && chip_en) && !advance) |=> $stable(addr_out) && $stable(sel_out));

  // R2
  cpu_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_stb && !chip_en && !ctl_stb && !advance) |=> $stable(addr_out));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_stb && !(cpu_stb && chip_en)) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !ctl_stb && !(cpu_stb && chip_en) && !order_sel && $stable(order_sel))
      |=> addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1));
endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/100ps
module test_burst_addr_gen;
  localparam int ADDR_W = 20;
  localparam int NV     = 21;
  // fields: req(4) ctl cpu ce adv mode addr_in(20) exp_addr(20) exp_sel
  localparam int VW = 4 + 5 + 20 + 20 + 1;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1,  5'b10100, 20'h12341, 20'h12341, 1'b1}, // R1 controller load
    {4'd4,  5'b00010, 20'h00000, 20'h12342, 1'b1}, // R4 linear
    {4'd4,  5'b00010, 20'h00000, 20'h12343, 1'b1},
    {4'd6,  5'b00010, 20'h00000, 20'h12340, 1'b1}, // R6 wrap, no carry
    {4'd10, 5'b00010, 20'h00000, 20'h12341, 1'b1}, // R10 back to start
    {4'd7,  5'b00000, 20'h00000, 20'h12341, 1'b1}, // R7 suspend
    {4'd2,  5'b01000, 20'hABCDE, 20'h12341, 1'b1}, // R2 gated strobe ignored
    {4'd2,  5'b01010, 20'hABCDE, 20'h12342, 1'b1}, // R2 advance passes
    {4'd2,  5'b01101, 20'hABCDE, 20'hABCDE, 1'b1}, // R2 processor load
    {4'd5,  5'b00011, 20'h00000, 20'hABCDF, 1'b1}, // R5 interleaved
    {4'd5,  5'b00011, 20'h00000, 20'hABCDC, 1'b1},
    {4'd5,  5'b00011, 20'h00000, 20'hABCDD, 1'b1},
    {4'd10, 5'b00011, 20'h00000, 20'hABCDE, 1'b1}, // R10
    {4'd3,  5'b11011, 20'h0FFFF, 20'h0FFFF, 1'b0}, // R3 both strobes, ce low
    {4'd5,  5'b00011, 20'h00000, 20'h0FFFE, 1'b0},
    {4'd5,  5'b00011, 20'h00000, 20'h0FFFD, 1'b0},
    {4'd6,  5'b00011, 20'h00000, 20'h0FFFC, 1'b0},
    {4'd8,  5'b10110, 20'h7FFFE, 20'h7FFFE, 1'b1}, // R8 load beats advance
    {4'd4,  5'b00010, 20'h00000, 20'h7FFFF, 1'b1},
    {4'd6,  5'b00010, 20'h00000, 20'h7FFFC, 1'b1}, // R6
    {4'd4,  5'b00010, 20'h00000, 20'h7FFFD, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              ctl_stb, cpu_stb, chip_en, advance, order_sel;
  logic [ADDR_W-1:0] addr_in;
  logic [ADDR_W-1:0] addr_out;
  logic              sel_out;
  int                n_chk = 0;
  int                n_bad = 0;
  bit                done  = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(2)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .ctl_stb(ctl_stb), .cpu_stb(cpu_stb),
    .chip_en(chip_en), .advance(advance), .order_sel(order_sel),
    .addr_in(addr_in), .addr_out(addr_out), .sel_out(sel_out)
  );

  task automatic check(input int req, input logic [ADDR_W-1:0] ea, input logic es);
    n_chk++;
    if (addr_out !== ea || sel_out !== es) begin
      n_bad++;
      $display("FAIL R%0d: addr=%h sel=%b expected addr=%h sel=%b",
               req, addr_out, sel_out, ea, es);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; ctl_stb = 0; cpu_stb = 0; chip_en = 0; advance = 0;
    order_sel = 0; addr_in = '0;
    repeat (3) @(posedge clk);
    #1 check(9, '0, 1'b0); // R9 reset state
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      {ctl_stb, cpu_stb, chip_en, advance, order_sel} = v[VW-5 -: 5];
      addr_in = v[ADDR_W*2 -: ADDR_W];
      @(posedge clk);
      #1 check(int'(v[VW-1 -: 4]), v[ADDR_W : 1], v[0]);
    end
    // R9 reset in mid burst clears address and select
    @(negedge clk);
    {ctl_stb, cpu_stb, chip_en, advance, order_sel} = 5'b00010;
    rst = 1'b1;
    @(posedge clk);
    #1 check(9, '0, 1'b0);
    // R7 after reset, idle holds zero
    @(negedge clk);
    rst = 1'b0; advance = 1'b0;
    @(posedge clk);
    #1 check(7, '0, 1'b0);
    done = 1'b1;
    finish_run();
  end
endmodule